// File: doc/BRIEF.md
# Three-Level Discharge Overcurrent Trip Detector

This block turns three digitised comparator flags from the discharge sense node into one latched overcurrent trip. The flags are ordered by threshold: bit 0 is the lowest, bit 2 the highest. The highest level is the load-short level. Each level has its own persistence timer and its own delay. The level-1 delay comes from a programmable input. The level-2 and level-3 delays are fixed parameters and much shorter. A higher level therefore trips before a slow lower-level timer expires, which lets it preempt that timer.

All delays are counts of tick strobes. The surrounding logic supplies a tick-enable that paces the timers, so the same block can serve millisecond-range delays or short bench runs. Once the block trips, it reports which level caused the trip and holds both outputs until the sense node recovers.

Recovery normally means the level-1 flag has dropped. When level 1 is inhibited, the level-2 flag must drop instead. An inhibit input stops level 1 from tripping and switches the release point to level 2.

Top module: `oc_trip_detect`

## Requirements
- R1: After reset, `tripActive` is 0 and `tripLevel` is 0.
- R2: If `levelFlags[0]` is held and level 1 is not inhibited, the block trips with `tripLevel` = 1 once `l1Delay` ticks have been counted. The outputs change on the clock edge after the tick that reaches the count.
- R3: If `levelFlags[1]` is held, the block trips with `tripLevel` = 2 after `L2_TICKS` ticks, using the same edge rule as R2.
- R4: If `levelFlags[2]` is held, the block trips with `tripLevel` = 3 after `L3_TICKS` ticks, using the same edge rule as R2.
- R5: When a level's flag drops, that level's timer clears at once. A later reassertion must count its full delay again.
- R6: Timers advance only on cycles where `tickEn` is 1. Cycles without a tick do not move any timer.
- R7: When several timers expire on the same cycle, or a higher level expires while a lower one is still counting, the reported level is the highest expired one.
- R8: While `inhibitL1` is 1, level 1 never causes a trip, however long `levelFlags[0]` is held.
- R9: With `inhibitL1` at 0, a trip clears on the edge after `levelFlags[0]` is seen low. While `levelFlags[0]` stays high, the trip holds even if higher flags drop.
- R10: With `inhibitL1` at 1, a trip clears on the edge after `levelFlags[1]` is seen low, even if `levelFlags[0]` is still high.
- R11: While the block is tripped, `tripLevel` does not change. All timers are held at zero, so after a release every level needs its full delay to trip again.
- R12: `tripActive` is 1 exactly when `tripLevel` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer advance strobe |
| levelFlags | input | 3 | Comparator flags; bit 0 is the lowest threshold, bit 2 the highest |
| inhibitL1 | input | 1 | Disables level 1 and moves the release point to level 2 |
| l1Delay | input | CNT_W | Level-1 delay in ticks |
| tripActive | output | 1 | Latched trip |
| tripLevel | output | 2 | Trip cause: 0 none, 1/2/3 = level |

## Verification
On every cycle, the assertions check the following:
- `tripActive` and `tripLevel` agree.
- A timer clears when its flag drops and stands still without a tick.
- The cause holds steady while the block is tripped.
- The release rule that applies for each inhibit setting is followed.
- No trip rises with level 1 as its cause while level 1 was inhibited.

Only the bench scenarios can show the exact trip cycle for each delay, preemption of the slow level-1 timer by faster levels, and a full restart after a flag dropout. They also show that a long inhibited level-1 hold leaves the outputs untouched.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;

  localparam int NUM_LEVELS = 3;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_TWO   = 2'd2,
    LVL_THREE = 2'd3
  } tripLvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     clrTimers;
    logic     latchCause;
    logic     dropCause;
    tripLvl_e cause;
  } ctrlStrobe_t;

endpackage

// File: rtl/oc_level_timer.sv
module oc_level_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             flag,
  input  logic             enable,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  assign armed = flag && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || !armed) begin
      cnt <= '0;
    end else if (tickEn && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = armed && (cnt >= limit);

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear || !armed) |=> (cnt == '0)); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && armed && !clear) |=> $stable(cnt)); // R6

endmodule

// File: rtl/oc_trip_datapath.sv
module oc_trip_datapath
  import oc_trip_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int L2_TICKS = 200,
  parameter int L3_TICKS = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tickEn,
  input  logic [NUM_LEVELS-1:0] levelFlags,
  input  logic                  inhibitL1,
  input  logic [CNT_W-1:0]      l1Delay,
  input  ctrlStrobe_t           strobe,
  output logic [NUM_LEVELS-1:0] expiredVec,
  output tripLvl_e              tripLevel
);

  localparam logic [CNT_W-1:0] L2_LIMIT = CNT_W'(L2_TICKS);
  localparam logic [CNT_W-1:0] L3_LIMIT = CNT_W'(L3_TICKS);

  logic [CNT_W-1:0]      limits [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] levelEn;
  tripLvl_e              causeQ;

  assign limits[0] = l1Delay;
  assign limits[1] = L2_LIMIT;
  assign limits[2] = L3_LIMIT;
  assign levelEn   = {2'b11, !inhibitL1};

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : gLevel
    oc_level_timer #(.CNT_W(CNT_W)) uTimer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tickEn (tickEn),
      .flag   (levelFlags[i]),
      .enable (levelEn[i]),
      .clear  (strobe.clrTimers),
      .limit  (limits[i]),
      .expired(expiredVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      causeQ <= LVL_NONE;
    end else if (strobe.latchCause) begin
      causeQ <= strobe.cause;
    end else if (strobe.dropCause) begin
      causeQ <= LVL_NONE;
    end
  end

  assign tripLevel = causeQ;

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (causeQ != LVL_NONE && !strobe.dropCause) |=> $stable(causeQ)); // R11

endmodule

// File: rtl/oc_trip_ctrl.sv
module oc_trip_ctrl
  import oc_trip_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] expiredVec,
  input  logic [NUM_LEVELS-1:0] levelFlags,
  input  logic                  inhibitL1,
  output ctrlStrobe_t           strobe,
  output logic                  tripActive
);

  typedef enum logic {ST_ARMED, ST_TRIPPED} state_e;

  state_e   stateQ, stateD;
  tripLvl_e topLvl;
  logic     releaseOk;

  // highest expired level wins
  always_comb begin
    if (expiredVec[2])      topLvl = LVL_THREE;
    else if (expiredVec[1]) topLvl = LVL_TWO;
    else if (expiredVec[0]) topLvl = LVL_ONE;
    else                    topLvl = LVL_NONE;
  end

  assign releaseOk = inhibitL1 ? !levelFlags[1] : !levelFlags[0];

  always_comb begin
    stateD            = stateQ;
    strobe.clrTimers  = (stateQ == ST_TRIPPED);
    strobe.latchCause = 1'b0;
    strobe.dropCause  = 1'b0;
    strobe.cause      = topLvl;
    if (stateQ == ST_ARMED) begin
      if (topLvl != LVL_NONE) begin
        strobe.latchCause = 1'b1;
        stateD            = ST_TRIPPED;
      end
    end else if (releaseOk) begin
      strobe.dropCause = 1'b1;
      stateD           = ST_ARMED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_ARMED;
    else        stateQ <= stateD;
  end

  assign tripActive = (stateQ == ST_TRIPPED);

  AST_RELEASE_BY_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (tripActive && !inhibitL1 && !levelFlags[0]) |=> !tripActive); // R9

  AST_HOLD_ABOVE_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (tripActive && !inhibitL1 && levelFlags[0]) |=> tripActive); // R9

  AST_RELEASE_BY_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (tripActive && inhibitL1 && !levelFlags[1]) |=> !tripActive); // R10

endmodule

// File: rtl/oc_trip_detect.sv
module oc_trip_detect
  import oc_trip_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int L2_TICKS = 200,
  parameter int L3_TICKS = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic [2:0]       levelFlags,
  input  logic             inhibitL1,
  input  logic [CNT_W-1:0] l1Delay,
  output logic             tripActive,
  output logic [1:0]       tripLevel
);

  ctrlStrobe_t           strobe;
  logic [NUM_LEVELS-1:0] expiredVec;
  tripLvl_e              causeLvl;

  oc_trip_datapath #(
    .CNT_W   (CNT_W),
    .L2_TICKS(L2_TICKS),
    .L3_TICKS(L3_TICKS)
  ) uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .tickEn    (tickEn),
    .levelFlags(levelFlags),
    .inhibitL1 (inhibitL1),
    .l1Delay   (l1Delay),
    .strobe    (strobe),
    .expiredVec(expiredVec),
    .tripLevel (causeLvl)
  );

  oc_trip_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .expiredVec(expiredVec),
    .levelFlags(levelFlags),
    .inhibitL1 (inhibitL1),
    .strobe    (strobe),
    .tripActive(tripActive)
  );

  assign tripLevel = causeLvl;

  AST_ACTIVE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tripActive == (tripLevel != 2'd0)); // R12

  AST_NO_INHIBITED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tripActive) && $past(inhibitL1)) |-> (tripLevel != 2'd1)); // R8

  AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripActive) |-> ($past(levelFlags) != 3'b000)); // R2

endmodule

// File: tb/oc_trip_detect_test.sv
module oc_trip_detect_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int L2T  = 12;
  localparam int L3T  = 3;
  localparam int L1D  = 30;

  typedef struct {
    int    lvl;
    int    at;
    string tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tickEn = 1'b1;
  logic [2:0]    levelFlags = 3'b000;
  logic          inhibitL1 = 1'b0;
  logic [CW-1:0] l1Delay = CW'(L1D);
  logic          tripActive;
  logic [1:0]    tripLevel;

  int       cyc = 0;
  int       nChecks = 0;
  int       nFails = 0;
  bit       rstDone = 1'b0;
  bit       finished = 1'b0;
  int       prevLvl = 0;
  expItem_t expQ[$];

  oc_trip_detect #(.CNT_W(CW), .L2_TICKS(L2T), .L3_TICKS(L3T)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tickEn    (tickEn),
    .levelFlags(levelFlags),
    .inhibitL1 (inhibitL1),
    .l1Delay   (l1Delay),
    .tripActive(tripActive),
    .tripLevel (tripLevel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAt(int lvl, int at, string tag);
    expItem_t e;
    e.lvl = lvl; e.at = at; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // monitor: pops expected changes and compares level and cycle
  always @(negedge clk) begin
    if (rstDone) begin
      int lvlNow;
      lvlNow = int'(tripLevel);
      check(tripActive == (tripLevel != 2'd0), "R12", int'(tripActive), int'(tripLevel != 2'd0));
      if (lvlNow != prevLvl) begin
        if (expQ.size() == 0) begin
          check(1'b0, "unexpected output change", lvlNow, prevLvl);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(lvlNow == e.lvl, e.tag, lvlNow, e.lvl);
          check(cyc == e.at, {e.tag, " cycle"}, cyc, e.at);
        end
        prevLvl = lvlNow;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    rstDone = 1'b1;
    check(tripActive == 1'b0, "R1 active", int'(tripActive), 0);
    check(tripLevel == 2'd0, "R1 level", int'(tripLevel), 0);

    // R2 level-1 trip, then R9 release
    levelFlags = 3'b001; expectAt(1, cyc + L1D + 1, "R2");
    step(L1D + 3);
    levelFlags = 3'b000; expectAt(0, cyc + 1, "R9 release");
    step(3);

    // R3 level 2 preempts slow level 1 (R7); latched while flag0 high (R9, R11)
    levelFlags = 3'b011; expectAt(2, cyc + L2T + 1, "R3 R7");
    step(L2T + 3);
    levelFlags = 3'b001;
    step(6);
    check(tripActive == 1'b1, "R9 hold", int'(tripActive), 1);
    check(tripLevel == 2'd2, "R11 cause held", int'(tripLevel), 2);
    levelFlags = 3'b000; expectAt(0, cyc + 1, "R9 release");
    step(3);

    // R4 level 3 short
    levelFlags = 3'b111; expectAt(3, cyc + L3T + 1, "R4 R7");
    step(L3T + 3);
    levelFlags = 3'b000; expectAt(0, cyc + 1, "R9 release");
    step(3);

    // R5 dropout restarts the timer
    levelFlags = 3'b001;
    step(20);
    levelFlags = 3'b000;
    step(1);
    levelFlags = 3'b001; expectAt(1, cyc + L1D + 1, "R5 restart");
    step(L1D + 3);
    levelFlags = 3'b000; expectAt(0, cyc + 1, "R9 release");
    step(3);

    // R6 no ticks, no progress
    tickEn = 1'b0; levelFlags = 3'b111;
    step(10);
    check(tripActive == 1'b0, "R6 no tick", int'(tripActive), 0);
    tickEn = 1'b1; expectAt(3, cyc + L3T + 1, "R6 resume");
    step(L3T + 3);
    levelFlags = 3'b000; expectAt(0, cyc + 1, "R9 release");
    step(3);

    // R7 simultaneous expiry of levels 1 and 2
    l1Delay = CW'(L2T);
    levelFlags = 3'b011; expectAt(2, cyc + L2T + 1, "R7 simultaneous");
    step(L2T + 3);
    levelFlags = 3'b000; expectAt(0, cyc + 1, "R9 release");
    step(3);
    l1Delay = CW'(L1D);

    // R8 inhibited level 1, R10 release at level 2
    inhibitL1 = 1'b1; levelFlags = 3'b001;
    step(2 * L1D);
    check(tripActive == 1'b0, "R8 inhibited", int'(tripActive), 0);
    levelFlags = 3'b011; expectAt(2, cyc + L2T + 1, "R3 inhibited");
    step(L2T + 3);
    levelFlags = 3'b001; expectAt(0, cyc + 1, "R10 release");
    step(L1D);
    check(tripActive == 1'b0, "R8 after release", int'(tripActive), 0);
    levelFlags = 3'b000; inhibitL1 = 1'b0;
    step(5);

    check(expQ.size() == 0, "pending expectations", expQ.size(), 0);
    finish();
  end

endmodule